// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits in the address stage of a 64-bit load/store pipeline. Each cycle it can accept one decoded memory access. The access is described by these fields:

- the access size, and whether the access moves a register pair;
- the addressing mode;
- a raw immediate field;
- the base register, the index register and the program counter.

From these it forms the effective address and the address of the following element. For the two indexed-update modes it also gives a new base value to write back. Any combination of size and mode that the load/store rules forbid sets an illegal flag.

The same stage also shapes the data for the register file. A loaded byte, halfword or word is zero- or sign-extended to a 32-bit or 64-bit destination. Store data is only trimmed to the access size.

All results are registered and appear one clock after the request, qualified by a valid bit.

Top module: `lsu_agu`

## Requirements
- R1: Mode code 0 (unscaled offset) gives address = base + imm[8:0] taken as a signed byte offset (-256..+255). It is legal for every single-register size. Size codes are 0=byte, 1=halfword, 2=word, 3=doubleword.
- R2: Mode code 1 (scaled offset) gives address = base + imm[11:0] as an unsigned count multiplied by the access size in bytes (0..4095 × size).
- R3: A pair access (is_pair=1) uses imm[6:0] as a signed count (-64..63) multiplied by the element size. It is legal only with mode 1, 2 or 3 and only with element size code 2 or 3. Every other pair combination raises illegal.
- R4: addr2 equals addr plus the access size in bytes. For a pair, this is where the second register goes.
- R5: Mode code 4 (PC-relative) gives address = pc + 4 × imm[18:0] taken as signed, which reaches about ±1 MB. It is legal only for single-register loads of size code 2 or 3. A store or a narrower size raises illegal.
- R6: Mode code 5 (register index) gives address = base + the extended index. idx_ext selects the extension: 0 zero-extends index[31:0], 1 sign-extends index[31:0], 2 uses all 64 bits, and 3 is illegal. When idx_scale=1 the index is shifted left by log2(size). A pair in this mode is illegal.
- R7: Mode code 2 (pre-index) gives address = base + offset and writes back base + offset. For single registers the offset is the signed 9-bit byte offset.
- R8: Mode code 3 (post-index) gives address = base unchanged and writes back base + offset.
- R9: wb_valid is high only for legal pre-index or post-index accesses. Mode codes 6 and 7 are always illegal.
- R10: For loads, ld_signed=1 sign-extends a byte, halfword or word, and ld_signed=0 zero-extends it. When dest_64=0, bits 63:32 of the result are zero.
- R11: For stores, data_out is raw_data with every bit above the access size cleared, whatever the values of ld_signed and dest_64.
- R12: Results appear exactly one clock after in_valid, with out_valid high for that one cycle. Synchronous reset clears out_valid and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| is_load | input | 1 | 1 = load, 0 = store |
| is_pair | input | 1 | Register-pair access |
| size | input | 2 | Access or element size code |
| mode | input | 3 | Addressing mode code |
| imm | input | 19 | Raw immediate field |
| base | input | 64 | Base register value |
| index | input | 64 | Index register value |
| idx_ext | input | 2 | Index extension select |
| idx_scale | input | 1 | Shift index by log2(size) |
| pc | input | 64 | Program counter |
| ld_signed | input | 1 | Sign-extend loaded data |
| dest_64 | input | 1 | Destination is 64 bits wide |
| raw_data | input | 64 | Loaded or store data |
| out_valid | output | 1 | Results valid |
| addr | output | 64 | Effective address |
| addr2 | output | 64 | Address of the following element |
| wb_valid | output | 1 | Base writeback requested |
| wb_value | output | 64 | New base value |
| illegal | output | 1 | Size/mode combination not allowed |
| data_out | output | 64 | Extended or trimmed data |

## Verification
A wrong offset selection or scale shows as a wrong addr or wb_value on the cycle after the request. It appears at the edges of the immediate range, for example -256, 4095 × 8 and -64 × 8. A legality decode that admits a forbidden pair, store or narrow PC-relative access shows as a missing illegal flag, often together with a spurious wb_valid, in the same output cycle. Because nothing is held across requests, every error shows on the very output cycle of the request that caused it and cannot hide until later.

// File: rtl/agu_pkg.sv
package agu_pkg;

    parameter int XLEN  = 64;
    parameter int IMM_W = 19;
    localparam int HALF = XLEN / 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        AM_UNSCALED = 3'd0,
        AM_SCALED   = 3'd1,
        AM_PRE      = 3'd2,
        AM_POST     = 3'd3,
        AM_PCREL    = 3'd4,
        AM_REGIDX   = 3'd5,
        AM_RSVD6    = 3'd6,
        AM_RSVD7    = 3'd7
    } addr_mode_e;

    typedef enum logic [1:0] {
        IX_ZEXT32 = 2'd0,
        IX_SEXT32 = 2'd1,
        IX_FULL   = 2'd2,
        IX_RSVD   = 2'd3
    } idx_ext_e;

    typedef struct packed {
        logic              is_load;
        logic              is_pair;
        acc_size_e         size;
        addr_mode_e        mode;
        logic [IMM_W-1:0]  imm;
        logic [XLEN-1:0]   base;
        logic [XLEN-1:0]   index;
        idx_ext_e          idx_ext;
        logic              idx_scale;
        logic [XLEN-1:0]   pc;
    } agu_req_t;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] addr2;
        logic            wb_valid;
        logic [XLEN-1:0] wb_value;
        logic            illegal;
        logic [XLEN-1:0] data;
    } agu_res_t;

    function automatic logic [XLEN-1:0] sext9(input logic [8:0] v);
        return {{(XLEN-9){v[8]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext7(input logic [6:0] v);
        return {{(XLEN-7){v[6]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext19(input logic [18:0] v);
        return {{(XLEN-19){v[18]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext12(input logic [11:0] v);
        return {{(XLEN-12){1'b0}}, v};
    endfunction

    function automatic logic [XLEN-1:0] size_bytes(input acc_size_e s);
        return {{(XLEN-1){1'b0}}, 1'b1} << s;
    endfunction

    function automatic logic is_indexed_update(input addr_mode_e m);
        return (m == AM_PRE) || (m == AM_POST);
    endfunction

endpackage

// File: rtl/agu_offset.sv
module agu_offset
    import agu_pkg::*;
(
    input  agu_req_t        req,
    output logic [XLEN-1:0] offset,
    output logic            use_pc,
    output logic            legal
);
    logic [XLEN-1:0] idx_ext_val;
    logic [1:0]      idx_shift;

    always_comb begin
        case (req.idx_ext)
            IX_ZEXT32: idx_ext_val = {{HALF{1'b0}}, req.index[HALF-1:0]};
            IX_SEXT32: idx_ext_val = {{HALF{req.index[HALF-1]}}, req.index[HALF-1:0]};
            default:   idx_ext_val = req.index;
        endcase
        idx_shift = req.idx_scale ? req.size : 2'd0;
    end

    always_comb begin
        offset = '0;
        use_pc = 1'b0;
        legal  = 1'b0;
        if (req.is_pair) begin
            offset = sext7(req.imm[6:0]) << req.size;
            legal  = req.size[1] &&
                     (req.mode == AM_SCALED || is_indexed_update(req.mode));
        end else begin
            case (req.mode)
                AM_UNSCALED, AM_PRE, AM_POST: begin
                    offset = sext9(req.imm[8:0]);
                    legal  = 1'b1;
                end
                AM_SCALED: begin
                    offset = zext12(req.imm[11:0]) << req.size;
                    legal  = 1'b1;
                end
                AM_PCREL: begin
                    offset = sext19(req.imm[18:0]) << 2;
                    use_pc = 1'b1;
                    legal  = req.is_load && req.size[1];
                end
                AM_REGIDX: begin
                    offset = idx_ext_val << idx_shift;
                    legal  = (req.idx_ext != IX_RSVD);
                end
                default: begin
                    offset = '0;
                    legal  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/agu_addr.sv
module agu_addr
    import agu_pkg::*;
(
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic            use_pc,
    input  logic            post,
    input  acc_size_e       size,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] addr2,
    output logic [XLEN-1:0] wb_value
);
    logic [XLEN-1:0] sum;

    always_comb begin
        sum      = (use_pc ? pc : base) + offset;
        addr     = post ? base : sum;
        addr2    = addr + size_bytes(size);
        wb_value = sum;
    end
endmodule

// File: rtl/agu_ldext.sv
module agu_ldext
    import agu_pkg::*;
(
    input  logic [XLEN-1:0] raw,
    input  acc_size_e       size,
    input  logic            is_load,
    input  logic            ld_signed,
    input  logic            dest_64,
    output logic [XLEN-1:0] data
);
    logic sx;

    always_comb begin
        sx = is_load && ld_signed;
        case (size)
            SZ_BYTE:  data = {{(XLEN-8){sx & raw[7]}}, raw[7:0]};
            SZ_HALF:  data = {{(XLEN-16){sx & raw[15]}}, raw[15:0]};
            SZ_WORD:  data = {{(XLEN-32){sx & raw[31]}}, raw[31:0]};
            default:  data = raw;
        endcase
        if (is_load && !dest_64) begin
            data[XLEN-1:HALF] = '0;
        end
    end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              is_load,
    input  logic              is_pair,
    input  logic [1:0]        size,
    input  logic [2:0]        mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    input  logic [1:0]        idx_ext,
    input  logic              idx_scale,
    input  logic [XLEN-1:0]   pc,
    input  logic              ld_signed,
    input  logic              dest_64,
    input  logic [XLEN-1:0]   raw_data,
    output logic              out_valid,
    output logic [XLEN-1:0]   addr,
    output logic [XLEN-1:0]   addr2,
    output logic              wb_valid,
    output logic [XLEN-1:0]   wb_value,
    output logic              illegal,
    output logic [XLEN-1:0]   data_out
);
    agu_req_t        req;
    agu_res_t        nxt;
    agu_res_t        res_q;
    logic            valid_q;
    logic [XLEN-1:0] offset;
    logic            use_pc;
    logic            legal;
    logic [XLEN-1:0] a_addr;
    logic [XLEN-1:0] a_addr2;
    logic [XLEN-1:0] a_wb;
    logic [XLEN-1:0] x_data;

    always_comb begin
        req.is_load   = is_load;
        req.is_pair   = is_pair;
        req.size      = acc_size_e'(size);
        req.mode      = addr_mode_e'(mode);
        req.imm       = imm;
        req.base      = base;
        req.index     = index;
        req.idx_ext   = idx_ext_e'(idx_ext);
        req.idx_scale = idx_scale;
        req.pc        = pc;
    end

    agu_offset u_offset (
        .req    (req),
        .offset (offset),
        .use_pc (use_pc),
        .legal  (legal)
    );

    agu_addr u_addr (
        .base     (req.base),
        .pc       (req.pc),
        .offset   (offset),
        .use_pc   (use_pc),
        .post     (req.mode == AM_POST),
        .size     (req.size),
        .addr     (a_addr),
        .addr2    (a_addr2),
        .wb_value (a_wb)
    );

    agu_ldext u_ldext (
        .raw       (raw_data),
        .size      (req.size),
        .is_load   (req.is_load),
        .ld_signed (ld_signed),
        .dest_64   (dest_64),
        .data      (x_data)
    );

    always_comb begin
        nxt.addr     = a_addr;
        nxt.addr2    = a_addr2;
        nxt.wb_valid = in_valid && legal && is_indexed_update(req.mode);
        nxt.wb_value = a_wb;
        nxt.illegal  = in_valid && !legal;
        nxt.data     = x_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= nxt;
            end else begin
                res_q.wb_valid <= 1'b0;
                res_q.illegal  <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign addr      = res_q.addr;
    assign addr2     = res_q.addr2;
    assign wb_valid  = res_q.wb_valid;
    assign wb_value  = res_q.wb_value;
    assign illegal   = res_q.illegal;
    assign data_out  = res_q.data;
endmodule

// File: rtl/lsu_agu_checker.sv
module lsu_agu_checker
    import agu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            is_load,
    input logic            is_pair,
    input logic [1:0]      size,
    input logic [2:0]      mode,
    input logic [XLEN-1:0] base,
    input logic            out_valid,
    input logic [XLEN-1:0] addr,
    input logic [XLEN-1:0] addr2,
    input logic            wb_valid,
    input logic            illegal,
    input logic [XLEN-1:0] data_out
);
    p_pcrel_narrow_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode) == 3'd4 &&
         (!$past(is_load) || $past(size) < 2'd2)) |-> illegal);

    p_post_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(mode) == 3'd3) |-> addr == $past(base));

    p_pair_next_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(is_pair)) |->
        addr2 == addr + ({{(XLEN-1){1'b0}}, 1'b1} << $past(size)));

    p_wb_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && wb_valid) |->
        (!illegal && ($past(mode) == 3'd2 || $past(mode) == 3'd3)));

    p_pair_regidx_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(is_pair) && $past(mode) >= 3'd4) |-> illegal);

    p_store_byte_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(is_load) && $past(size) == 2'd0) |->
        data_out[XLEN-1:8] == '0);

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal));
endmodule

bind lsu_agu lsu_agu_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .is_load   (is_load),
    .is_pair   (is_pair),
    .size      (size),
    .mode      (mode),
    .base      (base),
    .out_valid (out_valid),
    .addr      (addr),
    .addr2     (addr2),
    .wb_valid  (wb_valid),
    .illegal   (illegal),
    .data_out  (data_out)
);

// File: tb/lsu_agu_tb_top.sv
`timescale 1ns/1ps
module lsu_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        is_load = 1'b0;
    logic        is_pair = 1'b0;
    logic [1:0]  size = '0;
    logic [2:0]  mode = '0;
    logic [18:0] imm = '0;
    logic [63:0] base = '0;
    logic [63:0] index = '0;
    logic [1:0]  idx_ext = '0;
    logic        idx_scale = 1'b0;
    logic [63:0] pc = '0;
    logic        ld_signed = 1'b0;
    logic        dest_64 = 1'b0;
    logic [63:0] raw_data = '0;
    logic        out_valid;
    logic [63:0] addr;
    logic [63:0] addr2;
    logic        wb_valid;
    logic [63:0] wb_value;
    logic        illegal;
    logic [63:0] data_out;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    lsu_agu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .is_load(is_load),
        .is_pair(is_pair), .size(size), .mode(mode), .imm(imm), .base(base),
        .index(index), .idx_ext(idx_ext), .idx_scale(idx_scale), .pc(pc),
        .ld_signed(ld_signed), .dest_64(dest_64), .raw_data(raw_data),
        .out_valid(out_valid), .addr(addr), .addr2(addr2), .wb_valid(wb_valid),
        .wb_value(wb_value), .illegal(illegal), .data_out(data_out)
    );

    typedef struct {
        logic [63:0] addr;
        logic [63:0] addr2;
        logic        wbv;
        logic [63:0] wb;
        logic        ill;
        logic [63:0] data;
    } exp_t;

    function automatic exp_t model();
        exp_t   e;
        longint off;
        longint ixv;
        longint bsel;
        longint sum;
        longint unit;
        logic   ok;
        int     bits;
        logic [63:0] mask;
        logic [63:0] v;
        unit = longint'(1) << size;
        off  = 0;
        ok   = 1'b0;
        bsel = base;
        if (is_pair) begin
            off = longint'($signed(imm[6:0])) * unit;
            ok  = (size >= 2) && (mode == 1 || mode == 2 || mode == 3);
        end else begin
            case (mode)
                3'd0, 3'd2, 3'd3: begin off = longint'($signed(imm[8:0])); ok = 1'b1; end
                3'd1: begin off = longint'(imm[11:0]) * unit; ok = 1'b1; end
                3'd4: begin
                    off  = longint'($signed(imm)) * 4;
                    bsel = pc;
                    ok   = is_load && (size >= 2);
                end
                3'd5: begin
                    if (idx_ext == 0)      ixv = longint'(index[31:0]);
                    else if (idx_ext == 1) ixv = longint'($signed(index[31:0]));
                    else                   ixv = index;
                    off = idx_scale ? ixv * unit : ixv;
                    ok  = (idx_ext != 3);
                end
                default: ok = 1'b0;
            endcase
        end
        sum     = bsel + off;
        e.addr  = (mode == 3) ? base : sum;
        e.addr2 = e.addr + unit;
        e.wb    = sum;
        e.wbv   = ok && (mode == 2 || mode == 3);
        e.ill   = !ok;
        bits = 8 * int'(unit);
        mask = (size == 3) ? '1 : ((64'd1 << bits) - 64'd1);
        v    = raw_data & mask;
        if (is_load && ld_signed && size != 3 && raw_data[bits-1]) v = v | ~mask;
        if (is_load && !dest_64) v[63:32] = '0;
        e.data = v;
        return e;
    endfunction

    function automatic string tag_of();
        if (is_pair) return "R3";
        case (mode)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_one();
        exp_t  e;
        string t;
        e = model();
        t = tag_of();
        in_valid = 1'b1;
        @(negedge clk);
        chk("R12", "out_valid", {63'd0, out_valid}, 64'd1);
        chk(t, "illegal", {63'd0, illegal}, {63'd0, e.ill});
        chk("R9", "wb_valid", {63'd0, wb_valid}, {63'd0, e.wbv});
        if (!e.ill) begin
            chk(t, "addr", addr, e.addr);
            chk("R4", "addr2", addr2, e.addr2);
            if (e.wbv) chk(t, "wb_value", wb_value, e.wb);
        end
        chk(is_load ? "R10" : "R11", "data", data_out, e.data);
        in_valid = 1'b0;
    endtask

    task automatic set_req(input logic ld, input logic pr, input logic [1:0] sz,
                           input logic [2:0] md, input logic [18:0] im);
        is_load = ld; is_pair = pr; size = sz; mode = md; imm = im;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R12", "reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R12", "reset illegal", {63'd0, illegal}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "idle out_valid", {63'd0, out_valid}, 64'd0);

        base = 64'h0000_1000_0000_0000; pc = 64'h0000_0000_0040_0000;
        index = 64'h0000_0000_8000_0010; raw_data = 64'h1234_5678_9ABC_DEF0;

        set_req(1, 0, 2'd3, 3'd0, 19'h00100); run_one();   // R1 -256
        set_req(1, 0, 2'd0, 3'd0, 19'h000FF); run_one();   // R1 +255
        set_req(1, 0, 2'd3, 3'd1, 19'h00FFF); run_one();   // R2 4095*8
        set_req(1, 1, 2'd3, 3'd1, 19'h00040); run_one();   // R3 -64*8
        set_req(0, 1, 2'd2, 3'd2, 19'h0003F); run_one();   // R3/R7 +63*4
        set_req(1, 1, 2'd1, 3'd1, 19'h00001); run_one();   // R3 halfword pair illegal
        set_req(1, 1, 2'd3, 3'd0, 19'h00001); run_one();   // R3 pair unscaled illegal
        set_req(1, 1, 2'd3, 3'd5, 19'h00001); run_one();   // R3 pair regidx illegal
        set_req(1, 0, 2'd3, 3'd4, 19'h40000); run_one();   // R5 -1MB
        set_req(0, 0, 2'd3, 3'd4, 19'h00010); run_one();   // R5 store illegal
        set_req(1, 0, 2'd1, 3'd4, 19'h00010); run_one();   // R5 halfword illegal
        idx_ext = 2'd1; idx_scale = 1'b1;
        set_req(1, 0, 2'd2, 3'd5, 19'h0); run_one();       // R6 sign-extended, scaled
        idx_ext = 2'd0; idx_scale = 1'b0;
        set_req(1, 0, 2'd2, 3'd5, 19'h0); run_one();       // R6 zero-extended
        idx_ext = 2'd3;
        set_req(1, 0, 2'd2, 3'd5, 19'h0); run_one();       // R6 reserved
        set_req(1, 0, 2'd3, 3'd3, 19'h1FF80); run_one();   // R8 post -128
        set_req(1, 0, 2'd3, 3'd6, 19'h0); run_one();       // R9 reserved mode
        ld_signed = 1'b1; dest_64 = 1'b0;
        set_req(1, 0, 2'd0, 3'd0, 19'h0); run_one();       // R10 signed byte to 32
        dest_64 = 1'b1;
        set_req(1, 0, 2'd2, 3'd1, 19'h0); run_one();       // R10 signed word to 64
        set_req(0, 0, 2'd1, 3'd1, 19'h0); run_one();       // R11 store ignores signed

        for (int n = 0; n < 400; n++) begin
            is_load   = $urandom_range(0, 1);
            is_pair   = ($urandom_range(0, 3) == 0);
            size      = 2'($urandom_range(0, 3));
            mode      = 3'($urandom_range(0, 7));
            imm       = 19'($urandom);
            base      = {$urandom, $urandom};
            index     = {$urandom, $urandom};
            idx_ext   = 2'($urandom_range(0, 3));
            idx_scale = $urandom_range(0, 1);
            pc        = {$urandom, $urandom};
            ld_signed = $urandom_range(0, 1);
            dest_64   = $urandom_range(0, 1);
            raw_data  = {$urandom, $urandom};
            run_one();
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                chk("R12", "gap out_valid", {63'd0, out_valid}, 64'd0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule